// File: doc/BRIEF.md
# Debug Serial Port with Breakpoint Halt

This block is the target side of a slow serial link between an external debug host and a debug unit inside a chip. Every signal from the host is asynchronous to the system clock. The block synchronizes all three host inputs: the serial clock, the serial data and the breakpoint request. It treats a serial clock level as valid only once that level has been seen on two system clock cycles in a row. On each rising edge that the filter accepts, it takes in one command bit and moves the response output to its next bit. Both directions carry 17-bit packets, most significant bit first.

The response packet is one flag bit followed by 16 data bits. The block reads the response from its inputs while no packet is in progress. When a packet finishes, the block presents the 17-bit command word and pulses a done strobe for one cycle.

The block also turns a breakpoint request into a halt. The halt takes effect only on a cycle where the instruction-done strobe is high. While halted, the block drives the 4-bit status code 0xF. A resume input ends the halt.

Top module: `dbg_serial_port`

## Requirements
- R1: A serial clock level is accepted only after the two-flop synchronized serial clock shows the same value on two consecutive system clock edges. A high pulse lasting one system clock cycle produces no accepted edge.
- R2: On each accepted rising edge, the synchronized serial data bit is shifted in. After 17 accepted edges, `cmd_word_o` holds the 17 bits received, with the first bit received in bit 16.
- R3: `ser_dout_o` comes straight from a register. Before the first edge of a packet it shows bit 16 of `{rsp_flag_i, rsp_data_i}`. After accepted edge i (i from 1 to 16) it shows bit 16-i. It changes only on an accepted edge or, between packets, when the response inputs change.
- R4: `pkt_done_o` is high for exactly one cycle after the 17th accepted edge of a packet. `cmd_word_o` is updated in that same cycle.
- R5: `brk_req_i` passes through a two-flop synchronizer. A request is held pending. The halt is entered only on a cycle in which `insn_done_i` is high, so a request without that strobe never halts.
- R6: `status_o` is 4'hF while halted and 4'h0 otherwise. It is updated once per system clock cycle.
- R7: While halted, a high `resume_i` clears the halt and returns the status to 4'h0 on the next cycle. While not halted, `resume_i` has no effect.
- R8: A request that arrives while halted stays pending. If resume and instruction-done occur in the same cycle, resume wins and the halt is not re-entered in that cycle. The next instruction-done strobe after that halts again.
- R9: After synchronous reset, `ser_dout_o`, `pkt_done_o`, `halt_o`, `status_o` and `cmd_word_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Asynchronous serial clock from the host |
| ser_din_i | input | 1 | Asynchronous serial command data |
| brk_req_i | input | 1 | Asynchronous breakpoint request |
| insn_done_i | input | 1 | Instruction-completion strobe |
| resume_i | input | 1 | Leave the halted state |
| rsp_flag_i | input | 1 | Flag bit sent first in the response |
| rsp_data_i | input | 16 | Response data, sent after the flag |
| ser_dout_o | output | 1 | Registered serial response bit |
| cmd_word_o | output | 17 | Last complete command packet |
| pkt_done_o | output | 1 | One-cycle strobe when a packet completes |
| halt_o | output | 1 | Halted state |
| status_o | output | 4 | Status code: 0xF when halted, 0x0 otherwise |

## Verification
The serial path and the halt path run side by side, so the end of a packet and a halt entry can land in the same cycle. The bench provokes this by timing an instruction-done strobe against the final serial clock rise of a packet. It then requires that `pkt_done_o` and `halt_o` rise together. It also requires that the command word is complete and that the halt state matches a per-cycle behavioural model. A second collision, resume and instruction-done in the same cycle with a request pending, is judged by that model on every clock and by an explicit check that the halt is entered only at the following strobe.

// File: rtl/dsp_pkg.sv
// Shared types and constants for the debug serial port.
package dsp_pkg;
    localparam int unsigned STAT_W = 4;
    typedef logic [STAT_W-1:0] stat_t;
    localparam stat_t ST_RUN  = 4'h0;
    localparam stat_t ST_HALT = 4'hF;
endpackage

// File: rtl/dsp_sync.sv
// Multi-bit chain of flip-flops for bringing asynchronous inputs into clk.
// Assumes every bit is an independent level; there is no bus coherence.
module dsp_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES+1];

    assign chain[0] = d_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Purpose: one flop stage of the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g+1] <= '0;
            else        chain[g+1] <= chain[g];
        end
    end

    assign q_o = chain[STAGES];
endmodule

// File: rtl/dsp_level_filter.sv
// Accepts a new level only when two consecutive samples agree, and emits a
// one-cycle pulse for each accepted low-to-high change.
// Assumes lvl_i is already synchronous to clk.
module dsp_level_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;
    logic lvl_q;

    // Purpose: track last sample, accepted level and the rise pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            lvl_q  <= 1'b0;
            rise_o <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            rise_o <= (lvl_i == prev_q) && lvl_i && !lvl_q;
            if (lvl_i == prev_q) lvl_q <= lvl_i;
        end
    end

    assert_rise_needs_two_samples_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> ($past(lvl_i) && $past(lvl_i, 2)));
endmodule

// File: rtl/dsp_shifter.sv
// Packet shift engine: shifts command bits in and response bits out, MSB
// first, one bit per accepted serial clock rise.
// Assumes rise_i never holds high on two cycles in a row.
module dsp_shifter #(
    parameter int unsigned PKT_BITS = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_i,
    input  logic                din_i,
    input  logic [PKT_BITS-1:0] rsp_i,
    output logic                dout_o,
    output logic [PKT_BITS-1:0] word_o,
    output logic                done_o
);
    localparam int unsigned CNT_W = $clog2(PKT_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_BITS - 1);

    logic [CNT_W-1:0]    cnt_q;
    logic [PKT_BITS-2:0] rx_q;
    logic [PKT_BITS-1:0] tx_q;

    // Purpose: advance both shift registers and the bit count per accepted rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            word_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (rise_i) begin
                rx_q <= {rx_q[PKT_BITS-3:0], din_i};
                tx_q <= {tx_q[PKT_BITS-2:0], 1'b0};
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    word_o <= {rx_q, din_i};
                    done_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (cnt_q == '0) begin
                tx_q <= rsp_i;
            end
        end
    end

    assign dout_o = tx_q[PKT_BITS-1];

    assert_dout_holds_mid_packet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !rise_i) |=> $stable(dout_o));
    assert_done_after_last_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(rise_i) && $past(cnt_q) == LAST));
endmodule

// File: rtl/dsp_halt_ctrl.sv
// Breakpoint halt control: holds a pending request, enters the halt on an
// instruction-done strobe, leaves it on resume, and drives the status code.
// Assumes brk_i is already synchronized.
module dsp_halt_ctrl
    import dsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  brk_i,
    input  logic  done_i,
    input  logic  resume_i,
    output logic  halt_o,
    output stat_t status_o
);
    logic pend_q;
    logic enter;

    // Purpose: decide whether the halt starts this cycle.
    always_comb enter = !halt_o && (pend_q || brk_i) && done_i;

    // Purpose: update pending request, halted state and status code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            halt_o   <= 1'b0;
            status_o <= ST_RUN;
        end else begin
            pend_q <= (pend_q || brk_i) && !enter;
            if (halt_o && resume_i) begin
                halt_o   <= 1'b0;
                status_o <= ST_RUN;
            end else if (enter) begin
                halt_o   <= 1'b1;
                status_o <= ST_HALT;
            end
        end
    end

    assert_halt_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> $past(done_i));
    assert_status_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (status_o == ST_HALT));
    assert_status_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_o |-> (status_o == ST_RUN));
    assert_resume_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && resume_i) |=> !halt_o);
    assert_resume_beats_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && resume_i && done_i) |=> !halt_o);
endmodule

// File: rtl/dbg_serial_port.sv
// Top level of the debug serial port. It synchronizes the host inputs,
// filters the serial clock, runs the packet shifter and the halt controller.
// Assumes the serial clock runs at no more than one fifth of clk.
module dbg_serial_port #(
    parameter int unsigned PKT_BITS    = 17,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk_i,
    input  logic                ser_din_i,
    input  logic                brk_req_i,
    input  logic                insn_done_i,
    input  logic                resume_i,
    input  logic                rsp_flag_i,
    input  logic [PKT_BITS-2:0] rsp_data_i,
    output logic                ser_dout_o,
    output logic [PKT_BITS-1:0] cmd_word_o,
    output logic                pkt_done_o,
    output logic                halt_o,
    output logic [3:0]          status_o
);
    localparam int unsigned N_ASYNC = 3;

    logic [N_ASYNC-1:0] async_s;
    logic               sck_rise;

    dsp_sync #(.W(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({brk_req_i, ser_din_i, ser_clk_i}),
        .q_o   (async_s)
    );

    dsp_level_filter u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (async_s[0]),
        .rise_o (sck_rise)
    );

    dsp_shifter #(.PKT_BITS(PKT_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (sck_rise),
        .din_i  (async_s[1]),
        .rsp_i  ({rsp_flag_i, rsp_data_i}),
        .dout_o (ser_dout_o),
        .word_o (cmd_word_o),
        .done_o (pkt_done_o)
    );

    dsp_halt_ctrl u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .brk_i    (async_s[2]),
        .done_i   (insn_done_i),
        .resume_i (resume_i),
        .halt_o   (halt_o),
        .status_o (status_o)
    );
endmodule

// File: tb/dbg_serial_port_tb.sv
module dbg_serial_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk_i = 1'b0, ser_din_i = 1'b0, brk_req_i = 1'b0;
    logic        insn_done_i = 1'b0, resume_i = 1'b0, rsp_flag_i = 1'b0;
    logic [15:0] rsp_data_i = '0;
    logic        ser_dout_o, pkt_done_o, halt_o;
    logic [16:0] cmd_word_o;
    logic [3:0]  status_o;

    int  n_tests = 0, n_fail = 0, done_pulses = 0;
    bit  finished = 1'b0;
    bit  last_rise = 1'b0;
    // behavioural halt model state
    bit  m_halt = 0, m_pend = 0, m_b1 = 0, m_bs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_din_i(ser_din_i),
        .brk_req_i(brk_req_i), .insn_done_i(insn_done_i), .resume_i(resume_i),
        .rsp_flag_i(rsp_flag_i), .rsp_data_i(rsp_data_i), .ser_dout_o(ser_dout_o),
        .cmd_word_o(cmd_word_o), .pkt_done_o(pkt_done_o), .halt_o(halt_o),
        .status_o(status_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model of the halt path, advanced on every clock edge.
    always @(posedge clk) begin
        bit enter;
        if (!rst_n) begin
            m_halt = 0; m_pend = 0; m_b1 = 0; m_bs = 0;
        end else begin
            enter = !m_halt && (m_pend || m_bs) && insn_done_i;
            m_pend = (m_pend || m_bs) && !enter;
            if (m_halt && resume_i) m_halt = 0;
            else if (enter)         m_halt = 1;
            m_bs = m_b1;
            m_b1 = brk_req_i;
        end
    end

    // Compare the halt outputs with the model on every clock; count done pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(halt_o === m_halt, "R5 halt vs model", halt_o, m_halt);
            chk(status_o === (m_halt ? 4'hF : 4'h0), "R6 status vs model", status_o, m_halt ? 4'hF : 4'h0);
            if (pkt_done_o) done_pulses++;
        end
    end

    task automatic send_packet(input logic [16:0] cmd, input bit glitch);
        logic [16:0] rsp;
        int d0;
        rsp = {rsp_flag_i, rsp_data_i};
        d0  = done_pulses;
        repeat (2) @(negedge clk);
        chk(ser_dout_o === rsp[16], "R3 first response bit", ser_dout_o, rsp[16]);
        for (int i = 0; i < 17; i++) begin
            ser_clk_i = 1'b0;
            ser_din_i = cmd[16-i];
            repeat (3) @(negedge clk);
            if (glitch && i == 8) begin
                ser_clk_i = 1'b1;
                @(negedge clk);
                ser_clk_i = 1'b0;
                repeat (3) @(negedge clk);
            end
            if (i > 0)
                chk(ser_dout_o === rsp[16-i], "R3 response bit after edge", ser_dout_o, rsp[16-i]);
            ser_clk_i = 1'b1;
            if (i == 16) last_rise = 1'b1;
            repeat (3) @(negedge clk);
            last_rise = 1'b0;
        end
        ser_clk_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(cmd_word_o === cmd, glitch ? "R1 glitch ignored, word" : "R2 command word", cmd_word_o, cmd);
        chk(done_pulses - d0 == 1, "R4 one done pulse", done_pulses - d0, 1);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(ser_dout_o === 1'b0, "R9 dout reset", ser_dout_o, 0);
        chk(pkt_done_o === 1'b0, "R9 done reset", pkt_done_o, 0);
        chk(halt_o === 1'b0, "R9 halt reset", halt_o, 0);
        chk(status_o === 4'h0, "R9 status reset", status_o, 0);
        chk(cmd_word_o === 17'h0, "R9 word reset", cmd_word_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: plain packets with different patterns
        rsp_flag_i = 1'b1; rsp_data_i = 16'hBEEF;
        send_packet(17'h1A5C3, 1'b0);
        rsp_flag_i = 1'b0; rsp_data_i = 16'h8001;
        send_packet(17'h0FFFF, 1'b0);
        // R1: one-cycle glitch on the serial clock inside a packet
        rsp_flag_i = 1'b1; rsp_data_i = 16'h0F0F;
        send_packet(17'h15555, 1'b1);

        // R5: request without instruction-done never halts
        pulse(brk_req_i);
        repeat (10) @(negedge clk);
        chk(halt_o === 1'b0, "R5 no halt before boundary", halt_o, 0);
        pulse(insn_done_i);
        chk(halt_o === 1'b1, "R5 halt at boundary", halt_o, 1);
        chk(status_o === 4'hF, "R6 status halted", status_o, 4'hF);
        // R7: resume ends the halt next cycle
        pulse(resume_i);
        chk(halt_o === 1'b0, "R7 resume clears", halt_o, 0);
        chk(status_o === 4'h0, "R6 status running", status_o, 0);
        pulse(resume_i);
        chk(halt_o === 1'b0, "R7 resume when running", halt_o, 0);
        pulse(insn_done_i);
        chk(halt_o === 1'b0, "R5 done without request", halt_o, 0);

        // R8: request while halted, resume and done together, then re-halt
        pulse(brk_req_i);
        repeat (4) @(negedge clk);
        pulse(insn_done_i);
        chk(halt_o === 1'b1, "R8 halted again", halt_o, 1);
        pulse(brk_req_i);
        repeat (4) @(negedge clk);
        resume_i = 1'b1; insn_done_i = 1'b1;
        @(negedge clk);
        resume_i = 1'b0; insn_done_i = 1'b0;
        chk(halt_o === 1'b0, "R8 resume wins", halt_o, 0);
        repeat (3) @(negedge clk);
        chk(halt_o === 1'b0, "R8 still running", halt_o, 0);
        pulse(insn_done_i);
        chk(halt_o === 1'b1, "R8 pending request halts", halt_o, 1);
        pulse(resume_i);

        // Collision: packet completion and halt entry in the same cycle
        pulse(brk_req_i);
        rsp_flag_i = 1'b0; rsp_data_i = 16'h1234;
        fork
            send_packet(17'h0ACE1, 1'b0);
            begin
                @(posedge last_rise);
                repeat (4) @(negedge clk);
                insn_done_i = 1'b1;
                @(negedge clk);
                insn_done_i = 1'b0;
                chk(pkt_done_o === 1'b1, "R4 done in collision cycle", pkt_done_o, 1);
                chk(halt_o === 1'b1, "R5 halt in collision cycle", halt_o, 1);
            end
        join
        pulse(resume_i);
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule